// File: doc/BRIEF.md
# Four-Lane ChaCha Keystream XOR Unit

The unit takes one 16-word ChaCha base state and turns it into four consecutive keystream blocks at once. Each of the four lanes holds its own copy of the state. Lane n adds a fixed offset of n+1 to the block-counter word (word 12). All lanes run the same half-round in the same cycle. Every lane runs its four quarter-rounds side by side on its own words. Diagonal half-rounds are formed by muxing words within each lane, so no lane waits on another.

After the last round, each lane adds its starting state back in. Word 12 uses the lane's own counter value in this step. The result is 256 bytes of keystream. It is XORed with a 256-byte input buffer that is captured at start. The result leaves as 16-byte beats under valid/ready flow control. The caller gives a byte length from 1 to 256. Only the beats that hold requested bytes are sent. The final beat carries a byte-enable mask, and its unrequested bytes are driven to zero. The unit also reports how many 64-byte blocks the caller must advance the counter by.

Top module: `chacha4x_xor_stream`

## Requirements
- R1: A start pulse while idle captures state_i, len_i and din_i, and busy_o rises on the next cycle. The first beat is valid exactly NUM_ROUNDS+1 clock edges after the capturing edge (the capturing edge counts as the first). out_valid_o is never high while busy_o is low.
- R2: Lane n (0..3) uses a counter word equal to base word 12 + n + 1, taken modulo 2^32. The same lane value is used before the rounds and in the final addition. No carry ever reaches word 13.
- R3: Each lane's keystream is the ChaCha block function with NUM_ROUNDS rounds (default 20). Column half-rounds alternate with diagonal half-rounds, starting with a column half-round. The working state is then added to the lane's input state. Keystream word w of a lane gives bytes 4w..4w+3, least significant byte first.
- R4: Output stream byte k equals din_i byte k (bits 8k+7:8k) XOR keystream byte k mod 64 of lane k/64. Beat b carries stream bytes 16b..16b+15, with byte j on out_data_o bits 8j+7:8j.
- R5: A request of len bytes produces exactly ceil(len/16) beats. On beat b, out_keep_o bit j is set iff 16b+j < len, and data bytes whose keep bit is clear are zero. out_last_o is high only on the final beat.
- R6: While out_valid_o is high and out_ready_i is low, out_data_o, out_keep_o, out_last_o and out_valid_o hold their values into the next cycle.
- R7: When the final beat is accepted, done_o pulses for one cycle and busy_o falls in that same cycle. From the cycle after a start until the next start, ctr_adv_o equals ceil(len/64).
- R8: A start pulse while busy is ignored. The running request, its stream and its ctr_adv_o are unchanged.
- R9: state_i, len_i and din_i are used only at the capturing edge. Changing them during a run does not alter the output stream.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start_i | input | 1 | Start pulse, taken only when idle |
| len_i | input | 9 | Requested byte count, 1..256 |
| state_i | input | 512 | Base state, word w at bits 32w+31:32w |
| din_i | input | 2048 | Input buffer, byte k at bits 8k+7:8k |
| busy_o | output | 1 | A request is in progress |
| out_valid_o | output | 1 | Output beat valid |
| out_ready_i | input | 1 | Downstream accepts the beat |
| out_data_o | output | 128 | Output beat, byte j at bits 8j+7:8j |
| out_keep_o | output | 16 | Byte enables of the beat |
| out_last_o | output | 1 | Final beat of the request |
| done_o | output | 1 | One-cycle pulse after the final beat is accepted |
| ctr_adv_o | output | 3 | Counter advance, ceil(len/64) |

## Verification
A wrong lane counter, a swapped quarter-round index or a bad rotate damages every keystream word of the affected lane. The error therefore shows in the first beat that lane sends, at most 3 beats after its first byte is due, and a known public keystream word anchors the first lane. A wrong round count or phase sequencing moves the first valid beat away from its fixed cycle, or ends the run with an early or missing done pulse. Errors in the tail mask or last flag show on the final beat of lengths just above and below 16- and 64-byte boundaries. Stalls that let a beat change before it is accepted are caught in the cycle after the stall begins.

// File: rtl/c4x_pkg.sv
package c4x_pkg;

    typedef logic [31:0]       word_t;
    typedef logic [15:0][31:0] blk_t;

    typedef struct packed {
        word_t a;
        word_t b;
        word_t c;
        word_t d;
    } quad_t;

    // left rotate by a constant amount
    function automatic word_t rotl(input word_t x, input int n);
        return (x << n) | (x >> (32 - n));
    endfunction

    // rotate by 8 as a byte move: new bytes {b2,b1,b0,b3}
    function automatic word_t rotl8(input word_t x);
        return {x[23:16], x[15:8], x[7:0], x[31:24]};
    endfunction

    function automatic quad_t qround(input word_t a_i, input word_t b_i,
                                     input word_t c_i, input word_t d_i);
        word_t a, b, c, d;
        a = a_i; b = b_i; c = c_i; d = d_i;
        a = a + b; d = rotl(d ^ a, 16);
        c = c + d; b = rotl(b ^ c, 12);
        a = a + b; d = rotl8(d ^ a);
        c = c + d; b = rotl(b ^ c, 7);
        return '{a: a, b: b, c: c, d: d};
    endfunction

endpackage

// File: rtl/c4x_halfround.sv
module c4x_halfround
    import c4x_pkg::*;
(
    input  blk_t x_i,
    input  logic diag_i,
    output blk_t x_o
);
    blk_t y;
    blk_t z;

    // Row r shifts left by r words on a diagonal half-round, so that
    // the column quarter-rounds act on the diagonals.
    for (genvar r = 0; r < 4; r++) begin : g_row
        for (genvar c = 0; c < 4; c++) begin : g_col
            localparam int FWD = (c + r) % 4;
            localparam int BCK = (c - r + 4) % 4;
            assign y[4*r+c]   = diag_i ? x_i[4*r+FWD] : x_i[4*r+c];
            assign x_o[4*r+c] = diag_i ? z[4*r+BCK]   : z[4*r+c];
        end
    end

    for (genvar q = 0; q < 4; q++) begin : g_qr
        quad_t res;
        assign res      = qround(y[q], y[4+q], y[8+q], y[12+q]);
        assign z[q]     = res.a;
        assign z[4+q]   = res.b;
        assign z[8+q]   = res.c;
        assign z[12+q]  = res.d;
    end

endmodule

// File: rtl/c4x_beat_sel.sv
module c4x_beat_sel #(
    parameter  int LANES  = 4,
    localparam int BYTES  = LANES * 64,
    localparam int BEATS  = BYTES / 16,
    localparam int BEAT_W = $clog2(BEATS),
    localparam int LEN_W  = $clog2(BYTES + 1)
) (
    input  logic [BYTES*8-1:0] ks_i,
    input  logic [BYTES*8-1:0] din_i,
    input  logic [BEAT_W-1:0]  beat_i,
    input  logic [LEN_W-1:0]   len_i,
    output logic [127:0]       data_o,
    output logic [15:0]        keep_o,
    output logic               last_o
);
    logic [127:0] mixed;
    logic [LEN_W:0] base_pos;
    logic [LEN_W:0] len_x;

    always_comb begin
        mixed    = ks_i[beat_i*128 +: 128] ^ din_i[beat_i*128 +: 128];
        base_pos = (LEN_W+1)'({beat_i, 4'b0000});
        len_x    = {1'b0, len_i};
        for (int j = 0; j < 16; j++) begin
            keep_o[j]          = (base_pos + (LEN_W+1)'(j)) < len_x;
            data_o[8*j +: 8]   = keep_o[j] ? mixed[8*j +: 8] : 8'h00;
        end
        last_o = len_x <= (base_pos + (LEN_W+1)'(16));
    end

endmodule

// File: rtl/chacha4x_xor_stream.sv
module chacha4x_xor_stream
    import c4x_pkg::*;
#(
    parameter  int LANES      = 4,
    parameter  int NUM_ROUNDS = 20,
    parameter  int CTR_OFS    = 1,
    localparam int BYTES      = LANES * 64,
    localparam int LEN_W      = $clog2(BYTES + 1),
    localparam int ADV_W      = $clog2(LANES + 1)
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               start_i,
    input  logic [LEN_W-1:0]   len_i,
    input  logic [511:0]       state_i,
    input  logic [BYTES*8-1:0] din_i,
    output logic               busy_o,
    output logic               out_valid_o,
    input  logic               out_ready_i,
    output logic [127:0]       out_data_o,
    output logic [15:0]        out_keep_o,
    output logic               out_last_o,
    output logic               done_o,
    output logic [ADV_W-1:0]   ctr_adv_o
);
    localparam int BEATS  = BYTES / 16;
    localparam int BEAT_W = $clog2(BEATS);
    localparam int RND_W  = $clog2(NUM_ROUNDS);

    typedef enum logic [1:0] {PH_IDLE = 2'd0, PH_RUN = 2'd1, PH_OUT = 2'd2} phase_e;

    typedef struct packed {
        phase_e              ph;
        logic [RND_W-1:0]    rnd;
        logic [BEAT_W-1:0]   beat;
        logic [LEN_W-1:0]    len;
        logic                done;
        blk_t                base;
        blk_t [LANES-1:0]    work;
        logic [BYTES*8-1:0]  din;
    } regs_t;

    regs_t q, d;

    blk_t [LANES-1:0]   hr_out;
    logic [BYTES*8-1:0] ks_flat;
    logic               last_w;
    logic [LEN_W:0]     adv_sum;

    function automatic word_t lane_ctr(input word_t base12, input int lane);
        return base12 + word_t'(lane + CTR_OFS);
    endfunction

    // one half-round per lane, all lanes in lockstep
    for (genvar l = 0; l < LANES; l++) begin : g_lane
        c4x_halfround u_hr (
            .x_i    (q.work[l]),
            .diag_i (q.rnd[0]),
            .x_o    (hr_out[l])
        );
        // feed-forward with the lane's own counter in word 12
        for (genvar w = 0; w < 16; w++) begin : g_ff
            if (w == 12) begin : g_ctr
                assign ks_flat[l*512 + w*32 +: 32] =
                    q.work[l][w] + lane_ctr(q.base[12], l);
            end else begin : g_plain
                assign ks_flat[l*512 + w*32 +: 32] = q.work[l][w] + q.base[w];
            end
        end
    end

    c4x_beat_sel #(.LANES(LANES)) u_sel (
        .ks_i   (ks_flat),
        .din_i  (q.din),
        .beat_i (q.beat),
        .len_i  (q.len),
        .data_o (out_data_o),
        .keep_o (out_keep_o),
        .last_o (last_w)
    );

    always_comb begin
        d      = q;
        d.done = 1'b0;
        unique case (q.ph)
            PH_IDLE: begin
                if (start_i) begin
                    d.ph   = PH_RUN;
                    d.rnd  = '0;
                    d.beat = '0;
                    d.len  = len_i;
                    d.base = blk_t'(state_i);
                    d.din  = din_i;
                    for (int l = 0; l < LANES; l++) begin
                        d.work[l]     = blk_t'(state_i);
                        d.work[l][12] = lane_ctr(state_i[12*32 +: 32], l);
                    end
                end
            end
            PH_RUN: begin
                d.work = hr_out;
                d.rnd  = q.rnd + RND_W'(1);
                if (q.rnd == RND_W'(NUM_ROUNDS - 1)) begin
                    d.ph = PH_OUT;
                end
            end
            PH_OUT: begin
                if (out_ready_i) begin
                    if (last_w) begin
                        d.ph   = PH_IDLE;
                        d.done = 1'b1;
                    end else begin
                        d.beat = q.beat + BEAT_W'(1);
                    end
                end
            end
            default: d.ph = PH_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q <= '0;
        end else begin
            q <= d;
        end
    end

    assign adv_sum     = {1'b0, q.len} + (LEN_W+1)'(63);
    assign ctr_adv_o   = ADV_W'(adv_sum >> 6);
    assign busy_o      = q.ph != PH_IDLE;
    assign out_valid_o = q.ph == PH_OUT;
    assign out_last_o  = out_valid_o & last_w;
    assign done_o      = q.done;

endmodule

// File: rtl/c4x_chk.sv
module c4x_chk #(
    parameter  int LANES = 4,
    localparam int ADV_W = $clog2(LANES + 1)
) (
    input logic             clk,
    input logic             rst_n,
    input logic             start_i,
    input logic             busy_o,
    input logic             out_valid_o,
    input logic             out_ready_i,
    input logic [127:0]     out_data_o,
    input logic [15:0]      out_keep_o,
    input logic             out_last_o,
    input logic             done_o,
    input logic [ADV_W-1:0] ctr_adv_o
);
    // R6: stalled beat holds
    a_r6_stall_hold: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid_o && !out_ready_i |=> out_valid_o && $stable(out_data_o)
            && $stable(out_keep_o) && $stable(out_last_o));

    // R5: byte enables form a non-empty prefix
    a_r5_keep_prefix: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid_o |-> out_keep_o[0] && ((out_keep_o & (out_keep_o + 16'd1)) == 16'd0));

    // R5: a partially enabled beat must be the final one
    a_r5_partial_is_last: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid_o && (out_keep_o != 16'hFFFF) |-> out_last_o);

    // R1: no beat while idle
    a_r1_valid_in_busy: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid_o |-> busy_o);

    // R7: done follows acceptance of the final beat and ends busy
    a_r7_done_after_last: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |-> !busy_o && $past(out_valid_o && out_ready_i && out_last_o));

    // R8: start while busy leaves the counter advance alone
    a_r8_busy_start: assert property (@(posedge clk) disable iff (!rst_n)
        busy_o && start_i |=> $stable(ctr_adv_o));

endmodule

bind chacha4x_xor_stream c4x_chk #(.LANES(LANES)) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .start_i     (start_i),
    .busy_o      (busy_o),
    .out_valid_o (out_valid_o),
    .out_ready_i (out_ready_i),
    .out_data_o  (out_data_o),
    .out_keep_o  (out_keep_o),
    .out_last_o  (out_last_o),
    .done_o      (done_o),
    .ctr_adv_o   (ctr_adv_o)
);

// File: tb/sim_chacha4x_xor_stream.sv
`timescale 1ns/1ps
module sim_chacha4x_xor_stream;
    localparam int NR = 20;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          start_i = 1'b0;
    logic [8:0]    len_i = '0;
    logic [511:0]  state_i = '0;
    logic [2047:0] din_i = '0;
    logic          busy_o, out_valid_o, out_last_o, done_o;
    logic          out_ready_i = 1'b0;
    logic [127:0]  out_data_o;
    logic [15:0]   out_keep_o;
    logic [2:0]    ctr_adv_o;

    int n_chk = 0;
    int n_bad = 0;
    logic [31:0] first_word;

    always #10 clk = ~clk;

    chacha4x_xor_stream u0 (
        .clk(clk), .rst_n(rst_n), .start_i(start_i), .len_i(len_i),
        .state_i(state_i), .din_i(din_i), .busy_o(busy_o),
        .out_valid_o(out_valid_o), .out_ready_i(out_ready_i),
        .out_data_o(out_data_o), .out_keep_o(out_keep_o),
        .out_last_o(out_last_o), .done_o(done_o), .ctr_adv_o(ctr_adv_o)
    );

    task automatic chk(input bit ok, input string req,
                       input logic [127:0] act, input logic [127:0] exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    // ---- reference model from the requirements ----
    function automatic logic [31:0] rl(input logic [31:0] v, input int n);
        return (v << n) | (v >> (32 - n));
    endfunction

    function automatic logic [511:0] qr(input logic [511:0] v,
                                       input int a, input int b, input int c, input int e);
        logic [31:0] A, B, C, D;
        A = v[a*32 +: 32]; B = v[b*32 +: 32]; C = v[c*32 +: 32]; D = v[e*32 +: 32];
        A = A + B; D = rl(D ^ A, 16);
        C = C + D; B = rl(B ^ C, 12);
        A = A + B; D = rl(D ^ A, 8);
        C = C + D; B = rl(B ^ C, 7);
        v[a*32 +: 32] = A; v[b*32 +: 32] = B; v[c*32 +: 32] = C; v[e*32 +: 32] = D;
        return v;
    endfunction

    function automatic logic [511:0] ref_block(input logic [511:0] s, input int lane);
        logic [511:0] x, o;
        s[12*32 +: 32] = s[12*32 +: 32] + 32'(lane + 1);
        x = s;
        for (int i = 0; i < NR / 2; i++) begin
            x = qr(x, 0, 4, 8, 12);  x = qr(x, 1, 5, 9, 13);
            x = qr(x, 2, 6, 10, 14); x = qr(x, 3, 7, 11, 15);
            x = qr(x, 0, 5, 10, 15); x = qr(x, 1, 6, 11, 12);
            x = qr(x, 2, 7, 8, 13);  x = qr(x, 3, 4, 9, 14);
        end
        for (int w = 0; w < 16; w++) o[w*32 +: 32] = x[w*32 +: 32] + s[w*32 +: 32];
        return o;
    endfunction

    function automatic logic [511:0] mk_state(input int seed);
        logic [511:0] s;
        s[0*32 +: 32] = 32'h61707865; s[1*32 +: 32] = 32'h3320646e;
        s[2*32 +: 32] = 32'h79622d32; s[3*32 +: 32] = 32'h6b206574;
        for (int w = 4; w < 16; w++) s[w*32 +: 32] = 32'(seed * 32'h9e3779b9 + w * 32'h01000193);
        return s;
    endfunction

    // mode: 0 plain, 1 start pulse during run, 2 inputs changed during run
    task automatic run_case(input logic [511:0] st, input int len, input int seed,
                            input bit bp, input int mode, input string tag);
        logic [2047:0] dsave, ks;
        logic [127:0] exp_d;
        logic [15:0] exp_k;
        int n, nb, bi, cyc, k;
        @(negedge clk);
        for (int b = 0; b < 256; b++) din_i[8*b +: 8] = (seed < 0) ? 8'h00 : 8'(b * 37 + seed * 11 + 5);
        state_i = st; len_i = 9'(len); dsave = din_i;
        ks = {ref_block(st, 3), ref_block(st, 2), ref_block(st, 1), ref_block(st, 0)};
        start_i = 1'b1;
        @(negedge clk);
        start_i = 1'b0;
        n = 1;
        chk(busy_o, {tag, " R1 busy after start"}, 128'(busy_o), 128'd1);
        while (!out_valid_o && n < 200) begin
            if (n == 3 && mode == 1) begin start_i = 1'b1; len_i = 9'd7; state_i = ~st; end
            if (n == 4 && mode == 1) start_i = 1'b0;
            if (n == 3 && mode == 2) begin din_i = ~din_i; state_i = ~st; len_i = 9'd1; end
            @(negedge clk); n++;
        end
        chk(n == NR + 1, {tag, " R1 first-beat latency"}, 128'(n), 128'(NR + 1));
        nb = (len + 15) / 16; bi = 0; cyc = 0;
        while (bi < nb && cyc < 400) begin
            for (int j = 0; j < 16; j++) begin
                k = bi * 16 + j;
                exp_k[j] = k < len;
                exp_d[8*j +: 8] = exp_k[j] ? (dsave[8*k +: 8] ^ ks[8*k +: 8]) : 8'h00;
            end
            if (bi == 0) first_word = out_data_o[31:0];
            chk(out_valid_o && out_data_o == exp_d, {tag, " R4 R9 beat data"}, out_data_o, exp_d);
            chk(out_keep_o == exp_k, {tag, " R5 keep"}, 128'(out_keep_o), 128'(exp_k));
            chk(out_last_o == (bi == nb - 1), {tag, " R5 last"}, 128'(out_last_o), 128'(bi == nb - 1));
            out_ready_i = bp ? ((cyc % 3) != 1) : 1'b1;   // stalls exercise R6
            if (out_ready_i) bi++;
            @(negedge clk); cyc++;
        end
        out_ready_i = 1'b0;
        chk(done_o && !busy_o && !out_valid_o, {tag, " R7 done and idle"},
            128'({done_o, busy_o, out_valid_o}), 128'(3'b100));
        chk(ctr_adv_o == 3'((len + 63) / 64), {tag, " R7 counter advance"},
            128'(ctr_adv_o), 128'((len + 63) / 64));
        @(negedge clk);
        chk(!done_o, {tag, " R7 done single pulse"}, 128'(done_o), 128'd0);
    endtask

    task automatic t_reset;
        chk(!busy_o && !out_valid_o && !done_o && ctr_adv_o == 3'd0, "R1 R7 reset state",
            128'({busy_o, out_valid_o, done_o, ctr_adv_o}), 128'd0);
    endtask

    task automatic t_known_vector;   // R3 anchor: public test block
        logic [511:0] s;
        s = mk_state(0);
        for (int w = 0; w < 8; w++)
            s[(4+w)*32 +: 32] = {8'(4*w+3), 8'(4*w+2), 8'(4*w+1), 8'(4*w)};
        s[12*32 +: 32] = 32'h0;   // lane 0 runs with counter 1
        s[13*32 +: 32] = 32'h09000000;
        s[14*32 +: 32] = 32'h4a000000;
        s[15*32 +: 32] = 32'h00000000;
        run_case(s, 64, -1, 1'b0, 0, "R3 known");
        chk(first_word == 32'he4e7f110, "R3 known first keystream word",
            128'(first_word), 128'h e4e7f110);
    endtask

    task automatic t_full;   // R4 R6 full group with stalls
        run_case(mk_state(5), 256, 3, 1'b1, 0, "R4 full");
    endtask

    task automatic t_tails;  // R5 boundary lengths
        int lens[11] = '{1, 15, 16, 17, 63, 64, 65, 128, 129, 200, 255};
        foreach (lens[i]) run_case(mk_state(10 + i), lens[i], i, i % 2 == 1, 0, "R5 tail");
    endtask

    task automatic t_wrap;   // R2 counter wraps per lane, word 13 untouched
        logic [511:0] s;
        s = mk_state(7);
        s[12*32 +: 32] = 32'hFFFFFFFE;
        s[13*32 +: 32] = 32'h12345678;
        run_case(s, 256, 9, 1'b0, 0, "R2 wrap");
    endtask

    task automatic t_busy_start;  // R8
        run_case(mk_state(21), 150, 4, 1'b1, 1, "R8 busy start");
    endtask

    task automatic t_input_hold;  // R9
        run_case(mk_state(33), 100, 6, 1'b0, 2, "R9 input hold");
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_bad++;
        $display("FAIL watchdog expired actual=hung expected=finished");
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        t_reset();
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_known_vector();
        t_full();
        t_tails();
        t_wrap();
        t_busy_start();
        t_input_hold();
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

endmodule